// File: doc/BRIEF.md
# Dual Clock Missing-Edge Detector

This block watches two monitored clocks, a primary and a secondary, from a faster free-running system clock. It reports when either one stops toggling. Each monitored clock passes through a synchronizer. A rising edge is found by comparing the newest synchronized sample with the one before it. Each rising edge adds one to a small per-clock counter.

After every update the pair of counts is classified. If both counts are non-zero, the two clocks are alive and both counters return to zero. If one counter reaches the trip count (three by default) while the other is still zero, the silent clock is declared bad. A one-cycle switch request is raised in the same cycle as that declaration. The counters then restart, so monitoring continues.

Bad flags are sticky and clear only on the synchronous reset. Picking a clock and any multiplexing are left to the logic that consumes the flags and the switch request. The block has no data stream, so every pin is a plain control or status signal.

Top module: `clk_pair_watch`

## Requirements
- R1: While `sys_rst` is high at a `sys_clk` edge, both bad flags and `switch_req` go low and both edge counters clear to zero. Edges counted before the reset have no effect afterwards.
- R2: Each monitored clock is sampled through a synchronizer of `SYNC_STAGES` (default 2) flops. Each low-to-high transition counts exactly once, however long the high level is held. The system clock must run at least four times faster than the faster monitored clock.
- R3: When both counts are non-zero after an update, both counters return to zero. This covers the pairs (1,1), (1,2), (2,1) and (2,2), given as (primary, secondary).
- R4: When the primary count reaches `TRIP` (default 3) while the secondary count is zero, `bad_b` (secondary lost) sets.
- R5: When the secondary count reaches `TRIP` while the primary count is zero, `bad_a` (primary lost) sets.
- R6: `switch_req` is high for exactly one `sys_clk` cycle. It is high in the same cycle that a bad flag goes from low to high. It does not pulse for a detection whose flag is already set.
- R7: A bad flag stays set until reset, whatever the monitored clocks do afterwards.
- R8: After a detection, both counters restart from zero, so the other clock keeps being monitored and can also be flagged.
- R9: Simultaneous rising edges on both clocks count on both sides. A pair such as (3,1) therefore clears the counters with no detection.
- R10: A rising edge on a monitored input changes the counters on the third `sys_clk` rising edge after the transition. Any resulting flag and pulse appear on that same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sys_clk | input | 1 | Free-running sampling clock |
| sys_rst | input | 1 | Synchronous reset, active high |
| mon_clk_a | input | 1 | Primary monitored clock |
| mon_clk_b | input | 1 | Secondary monitored clock |
| bad_a | output | 1 | Sticky flag: primary clock missed edges |
| bad_b | output | 1 | Sticky flag: secondary clock missed edges |
| switch_req | output | 1 | One-cycle switch request at a new detection |

## Verification
The assertions check on every cycle that the switch pulse lasts one cycle and coincides with a newly set flag. They also check that flags never drop outside reset and that the counters never both hold non-zero values across an edge. A further assertion checks that a flag sets only from the count pair just below the trip point with the other side at zero.

Only the bench scenarios show which edge orderings are treated as balanced. These include interleaved, bunched and simultaneous edges. The same holds for counter clearing by reset partway through a count, for single counting of a long high level, and for both flags being raised in turn.

// File: rtl/cpw_pkg.sv
package cpw_pkg;
  localparam int unsigned CPW_NCH       = 2;
  localparam int unsigned CPW_SYNC_DEF  = 2;
  localparam int unsigned CPW_TRIP_DEF  = 3;
  localparam int          CPW_CH_A      = 0;
  localparam int          CPW_CH_B      = 1;
endpackage

// File: rtl/cpw_edge_det.sv
// Synchronizes one monitored clock into the system domain and
// emits a one-cycle strobe per low-to-high transition (R2).
module cpw_edge_det #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], din};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/cpw_pair_cnt.sv
// Paired edge counters with balanced-clear and trip detection
// (R3, R4, R5, R8, R9).
module cpw_pair_cnt #(
  parameter int unsigned TRIP = 3,
  parameter int unsigned CW   = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rise_a,
  input  logic          rise_b,
  output logic [CW-1:0] cnt_a,
  output logic [CW-1:0] cnt_b,
  output logic          miss_a,
  output logic          miss_b
);
  logic [CW-1:0] nxt_a, nxt_b;
  logic          alive;

  always_comb begin
    nxt_a  = cnt_a + CW'(rise_a);
    nxt_b  = cnt_b + CW'(rise_b);
    // secondary piled up edges while primary stayed silent
    miss_a = (nxt_b >= CW'(TRIP)) && (nxt_a == '0);
    // primary piled up edges while secondary stayed silent
    miss_b = (nxt_a >= CW'(TRIP)) && (nxt_b == '0);
    alive  = (nxt_a != '0) && (nxt_b != '0);
  end

  always_ff @(posedge clk) begin
    if (rst || alive || miss_a || miss_b) begin
      cnt_a <= '0;
      cnt_b <= '0;
    end else begin
      cnt_a <= nxt_a;
      cnt_b <= nxt_b;
    end
  end
endmodule

// File: rtl/cpw_flags.sv
// Sticky loss flags and the single-cycle switch request (R6, R7).
module cpw_flags (
  input  logic clk,
  input  logic rst,
  input  logic miss_a,
  input  logic miss_b,
  output logic bad_a,
  output logic bad_b,
  output logic switch_req
);
  always_ff @(posedge clk) begin
    if (rst) begin
      bad_a      <= 1'b0;
      bad_b      <= 1'b0;
      switch_req <= 1'b0;
    end else begin
      bad_a      <= bad_a | miss_a;
      bad_b      <= bad_b | miss_b;
      switch_req <= (miss_a & ~bad_a) | (miss_b & ~bad_b);
    end
  end
endmodule

// File: rtl/clk_pair_watch.sv
module clk_pair_watch
  import cpw_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = CPW_SYNC_DEF,
  parameter int unsigned TRIP        = CPW_TRIP_DEF
) (
  input  logic sys_clk,
  input  logic sys_rst,
  input  logic mon_clk_a,
  input  logic mon_clk_b,
  output logic bad_a,
  output logic bad_b,
  output logic switch_req
);
  localparam int unsigned CW = $clog2(TRIP + 1);

  logic [CPW_NCH-1:0] mon_raw;
  logic [CPW_NCH-1:0] rise;
  logic [CW-1:0]      cnt_a, cnt_b;
  logic               miss_a, miss_b;

  assign mon_raw = {mon_clk_b, mon_clk_a};

  for (genvar gi = 0; gi < CPW_NCH; gi++) begin : g_ch
    cpw_edge_det #(.STAGES(SYNC_STAGES)) u_det (
      .clk  (sys_clk),
      .rst  (sys_rst),
      .din  (mon_raw[gi]),
      .rise (rise[gi])
    );
  end

  cpw_pair_cnt #(.TRIP(TRIP), .CW(CW)) u_cnt (
    .clk    (sys_clk),
    .rst    (sys_rst),
    .rise_a (rise[CPW_CH_A]),
    .rise_b (rise[CPW_CH_B]),
    .cnt_a  (cnt_a),
    .cnt_b  (cnt_b),
    .miss_a (miss_a),
    .miss_b (miss_b)
  );

  cpw_flags u_flg (
    .clk        (sys_clk),
    .rst        (sys_rst),
    .miss_a     (miss_a),
    .miss_b     (miss_b),
    .bad_a      (bad_a),
    .bad_b      (bad_b),
    .switch_req (switch_req)
  );
endmodule

// File: rtl/cpw_checker.sv
module cpw_checker #(
  parameter int unsigned TRIP = 3,
  parameter int unsigned CW   = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          bad_a,
  input logic          bad_b,
  input logic          switch_req,
  input logic [CW-1:0] cnt_a,
  input logic [CW-1:0] cnt_b
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!bad_a && !bad_b && !switch_req && cnt_a == '0 && cnt_b == '0));

  a_r3_no_live_pair: assert property (@(posedge clk) disable iff (rst)
    !(cnt_a != '0 && cnt_b != '0));

  a_r4_trip_origin_b: assert property (@(posedge clk) disable iff (rst)
    (bad_b && !$past(bad_b)) |->
      ($past(cnt_a) == CW'(TRIP - 1) && $past(cnt_b) == '0));

  a_r5_trip_origin_a: assert property (@(posedge clk) disable iff (rst)
    (bad_a && !$past(bad_a)) |->
      ($past(cnt_b) == CW'(TRIP - 1) && $past(cnt_a) == '0));

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
    switch_req |=> !switch_req);

  a_r6_pulse_new_flag: assert property (@(posedge clk) disable iff (rst)
    switch_req |-> ((bad_a && !$past(bad_a)) || (bad_b && !$past(bad_b))));

  a_r6_flag_raises_pulse: assert property (@(posedge clk) disable iff (rst)
    ($rose(bad_a) || $rose(bad_b)) |-> switch_req);

  a_r7_sticky_a: assert property (@(posedge clk) disable iff (rst)
    bad_a |=> bad_a);

  a_r7_sticky_b: assert property (@(posedge clk) disable iff (rst)
    bad_b |=> bad_b);
endmodule

bind clk_pair_watch cpw_checker #(.TRIP(TRIP), .CW(CW)) u_chk (
  .clk        (sys_clk),
  .rst        (sys_rst),
  .bad_a      (bad_a),
  .bad_b      (bad_b),
  .switch_req (switch_req),
  .cnt_a      (cnt_a),
  .cnt_b      (cnt_b)
);

// File: tb/clk_pair_watch_tb.sv
`timescale 1ns/1ps
module clk_pair_watch_tb;
  logic sys_clk = 1'b0;
  logic sys_rst = 1'b1;
  logic mon_a = 1'b0;
  logic mon_b = 1'b0;
  logic bad_a, bad_b, switch_req;

  int checks = 0;
  int fails  = 0;
  int pulses = 0;
  int run_len = 0;
  int max_run = 0;
  bit done = 1'b0;

  always #2.5 sys_clk = ~sys_clk;

  clk_pair_watch u_dut (
    .sys_clk    (sys_clk),
    .sys_rst    (sys_rst),
    .mon_clk_a  (mon_a),
    .mon_clk_b  (mon_b),
    .bad_a      (bad_a),
    .bad_b      (bad_b),
    .switch_req (switch_req)
  );

  // Script: 8 steps of 2 bits, step 0 in [19:18]; bit1 = primary rise,
  // bit0 = secondary rise. Then exp bad_a, exp bad_b, exp pulse count.
  localparam int NVEC = 12;
  localparam logic [19:0] VEC [NVEC] = '{
    {16'h9999, 1'b0, 1'b0, 2'd0},  // alternating, balanced   R3
    {16'hA800, 1'b0, 1'b1, 2'd1},  // primary only            R4
    {16'h5400, 1'b1, 1'b0, 2'd1},  // secondary only          R5
    {16'h9600, 1'b0, 1'b0, 2'd0},  // a b b a                 R3
    {16'hA554, 1'b1, 1'b0, 2'd1},  // (2,1) clear then b x3   R3 R5
    {16'hFC00, 1'b0, 1'b0, 2'd0},  // simultaneous            R9
    {16'hAEA0, 1'b0, 1'b1, 2'd1},  // (3,1) clears, then a x3 R9 R4
    {16'hAAA0, 1'b0, 1'b1, 2'd1},  // a x6: second trip, no pulse R6 R8
    {16'hA950, 1'b1, 1'b1, 2'd2},  // both flagged in turn    R8
    {16'h9A80, 1'b0, 1'b1, 2'd1},  // (1,1) clear then a x3   R3 R4
    {16'hA680, 1'b0, 1'b0, 2'd0},  // (2,1) then (2,0)        R3
    {16'h5940, 1'b0, 1'b0, 2'd0}   // (1,2) then (0,2)        R3
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge sys_clk) begin
    if (switch_req) begin
      pulses++;
      run_len++;
      if (run_len > max_run) max_run = run_len;
      // R6: flag must already show in the pulse cycle
      check("R6 flag with pulse", int'(bad_a | bad_b), 1);
    end else begin
      run_len = 0;
    end
  end

  task automatic do_reset();
    @(negedge sys_clk);
    sys_rst = 1'b1;
    mon_a = 1'b0;
    mon_b = 1'b0;
    repeat (4) @(negedge sys_clk);
    sys_rst = 1'b0;
    repeat (4) @(negedge sys_clk);
  endtask

  task automatic step(input logic [1:0] s, input int hold);
    mon_a = s[1];
    mon_b = s[0];
    repeat (hold) @(negedge sys_clk);
    mon_a = 1'b0;
    mon_b = 1'b0;
    repeat (4) @(negedge sys_clk);
  endtask

  initial begin
    repeat (100000) @(posedge sys_clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int p0;
    do_reset();
    // R1: reset state
    check("R1 bad_a after reset", int'(bad_a), 0);
    check("R1 bad_b after reset", int'(bad_b), 0);
    check("R1 switch_req after reset", int'(switch_req), 0);

    for (int v = 0; v < NVEC; v++) begin
      do_reset();
      p0 = pulses;
      for (int s = 0; s < 8; s++) step(VEC[v][19 - 2*s -: 2], 4);
      repeat (6) @(negedge sys_clk);
      check($sformatf("R4/R5 vec%0d bad_a", v), int'(bad_a), int'(VEC[v][3]));
      check($sformatf("R4/R5 vec%0d bad_b", v), int'(bad_b), int'(VEC[v][2]));
      check($sformatf("R6 vec%0d pulses", v), pulses - p0, int'(VEC[v][1:0]));
    end

    // R1: reset partway through a count discards earlier edges
    do_reset();
    step(2'b10, 4);
    step(2'b10, 4);
    @(negedge sys_clk);
    sys_rst = 1'b1;
    repeat (2) @(negedge sys_clk);
    sys_rst = 1'b0;
    repeat (4) @(negedge sys_clk);
    step(2'b10, 4);
    step(2'b10, 4);
    repeat (6) @(negedge sys_clk);
    check("R1 counters cleared by reset", int'(bad_b), 0);
    step(2'b10, 4);
    repeat (6) @(negedge sys_clk);
    check("R4 trip after reset", int'(bad_b), 1);

    // R7: flag holds while secondary recovers, until reset
    for (int i = 0; i < 6; i++) step(2'b01, 4);
    repeat (6) @(negedge sys_clk);
    check("R7 bad_b sticky", int'(bad_b), 1);
    do_reset();
    check("R7 bad_b cleared by reset", int'(bad_b), 0);

    // R2: long high level counts once
    do_reset();
    step(2'b10, 30);
    step(2'b10, 30);
    repeat (6) @(negedge sys_clk);
    check("R2 long high counts once", int'(bad_b), 0);
    step(2'b10, 4);
    repeat (6) @(negedge sys_clk);
    check("R2 third rise trips", int'(bad_b), 1);

    // R10: latency of the trip from the third rise
    do_reset();
    step(2'b10, 4);
    step(2'b10, 4);
    mon_a = 1'b1;                    // driven at a negedge
    @(negedge sys_clk);              // edge 1 passed
    @(negedge sys_clk);              // edge 2 passed
    check("R10 no flag after two edges", int'(bad_b), 0);
    @(negedge sys_clk);              // edge 3 passed
    check("R10 flag on third edge", int'(bad_b), 1);
    check("R10 pulse on third edge", int'(switch_req), 1);
    mon_a = 1'b0;
    repeat (4) @(negedge sys_clk);

    // R6: pulse width over the whole run
    check("R6 max pulse width", max_run, 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule